// File: doc/BRIEF.md
# Status Flag Mask Set Unit

This unit executes the "set selected status flags" instruction of a small processor core. It takes a 16-bit instruction word over a valid/ready handshake. The word is recognised when its upper byte carries the fixed opcode 0x3B. Its lower byte is then an immediate mask, and every selected flag is forced to one. Flags whose mask bit is clear keep their value. The eight mask bits are split across two 4-bit status words. The low nibble drives the first word: sign-extension mode, overflow mode, test/control and carry. The high nibble drives the second word: global interrupt mask, debug mask, page-0 addressing and vector map.

Most masks finish in one cycle. A mask that touches the interrupt-mask or debug-mask flag needs a second cycle, and every selected flag lands together at the end of that second cycle. The instruction cannot be repeated: if a repeat count is pending when the instruction is accepted, the unit pulses a clear request to the repeat counter and still executes exactly once.

Back-pressure works as follows. A word is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low only during the second cycle of a two-cycle execution, and anything offered then is left untaken. Words with a foreign opcode are still taken, but they are discarded.

Top module: `stat_mask_set`

## Requirements
- R1: A taken word whose bits [15:8] differ from 0x3B changes no flag, produces no `done` and no `rpt_clr`.
- R2: For a recognised word, mask bits 0..3 set bits 0..3 of `st_lo`, in the order sign-extension, overflow, test/control, carry.
- R3: For a recognised word, mask bits 4..7 set bits 0..3 of `st_hi`, in the order interrupt mask, debug mask, page-0, vector map.
- R4: Flags whose mask bit is 0 keep their previous value; a flag is never cleared except by reset.
- R5: When mask bits 4 and 5 are both 0, `done` and the new flag values appear in the cycle right after the accepting edge, and `in_ready` stays high.
- R6: When mask bit 4 or 5 is 1, the cycle after acceptance shows `done` low, unchanged flags and `in_ready` low. The next cycle shows `done` high and all selected flags, in both words, updated on the same edge.
- R7: While `in_ready` is low, an offered word is not taken and has no effect on flags or `done`.
- R8: `done` is high for exactly one cycle per recognised instruction.
- R9: If `rpt_cnt` is nonzero when a recognised word is taken, `rpt_clr` is high for exactly one cycle, the cycle after acceptance. The instruction completes exactly once. With `rpt_cnt` zero, `rpt_clr` stays low.
- R10: Mask 0x00 is legal: no flag changes and `done` follows in one cycle.
- R11: A synchronous reset clears `st_lo`, `st_hi`, `done` and `rpt_clr`, and leaves `in_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Unit can take a word this cycle |
| in_word | input | 16 | Instruction word: opcode byte above, mask byte below |
| rpt_cnt | input | 16 | Current repeat counter value |
| rpt_clr | output | 1 | Request to zero the repeat counter |
| st_lo | output | 4 | First status word flags |
| st_hi | output | 4 | Second status word flags |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can meet in one cycle: the final commit of a two-cycle mask, and a new word offered while `in_ready` is low. The bench sweeps all 256 masks over a varied flag preset. On every two-cycle mask it offers an all-ones word during the stalled cycle. It then checks that the flags equal exactly the held result, that `done` pulses once, and that the intruder never appears as a later update or completion. Repeat-clear timing and foreign-opcode words are checked in the same sweep.

// File: rtl/smsu_pkg.sv
package smsu_pkg;
  localparam int          OPC_W     = 8;
  localparam logic [7:0]  OPC_SETM  = 8'h3B;
  // mask bits whose flags need a second execution cycle
  localparam logic [7:0]  SLOW_BITS = 8'h30;
  typedef enum logic {ST_IDLE, ST_HOLD} smsu_st_e;
endpackage

// File: rtl/smsu_decode.sv
module smsu_decode
  import smsu_pkg::*;
#(
  parameter int IW = 16,
  parameter int MW = 8
) (
  input  logic [IW-1:0] word,
  output logic          match,
  output logic [MW-1:0] mask,
  output logic          long_op
);
  assign mask    = word[MW-1:0];
  assign match   = (word[IW-1:MW] == OPC_SETM);
  assign long_op = |(mask & SLOW_BITS);
endmodule

// File: rtl/smsu_flags.sv
module smsu_flags #(
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [BW-1:0] set_bits,
  output logic [BW-1:0] q
);
  for (genvar i = 0; i < BW; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                   q[i] <= 1'b0;
      else if (we && set_bits[i]) q[i] <= 1'b1;
    end
  end

  // R4
  flags_monotone_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((q & $past(q)) == $past(q)));
  // R4
  flags_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q));
endmodule

// File: rtl/smsu_ctrl.sv
module smsu_ctrl
  import smsu_pkg::*;
#(
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          match,
  input  logic          long_op,
  input  logic [MW-1:0] in_mask,
  input  logic          rpt_nz,
  output logic          fire,
  output logic [MW-1:0] set_mask,
  output logic          done,
  output logic          rpt_clr
);
  smsu_st_e      state;
  logic [MW-1:0] held;
  logic          accept;

  assign in_ready = (state == ST_IDLE);
  assign accept   = in_valid && in_ready;
  assign fire     = (accept && match && !long_op) || (state == ST_HOLD);
  assign set_mask = (state == ST_HOLD) ? held : in_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      held    <= '0;
      done    <= 1'b0;
      rpt_clr <= 1'b0;
    end else begin
      done    <= fire;
      rpt_clr <= accept && match && rpt_nz;
      if (accept && match && long_op) begin
        state <= ST_HOLD;
        held  <= in_mask;
      end else if (state == ST_HOLD) begin
        state <= ST_IDLE;
      end
    end
  end

  // R5
  short_done_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && match && !long_op) |=> (done && in_ready));
  // R6
  long_done_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && match && long_op) |=> (!done && !in_ready) ##1 done);
  // R1
  foreign_word_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && !match) |=> (!done && !rpt_clr));
  // R9
  rpt_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && match && rpt_nz) |=> rpt_clr ##1 !rpt_clr);
  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> (in_ready && $stable(held)));
  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!done && !rpt_clr && in_ready));
endmodule

// File: rtl/stat_mask_set.sv
module stat_mask_set
  import smsu_pkg::*;
#(
  parameter int IW  = 16,
  parameter int MW  = 8,
  parameter int RCW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [IW-1:0]  in_word,
  input  logic [RCW-1:0] rpt_cnt,
  output logic           rpt_clr,
  output logic [MW/2-1:0] st_lo,
  output logic [MW/2-1:0] st_hi,
  output logic           done
);
  localparam int BW = MW / 2;

  logic          match, long_op, fire;
  logic [MW-1:0] in_mask, set_mask;

  smsu_decode #(.IW(IW), .MW(MW)) u_dec (
    .word    (in_word),
    .match   (match),
    .mask    (in_mask),
    .long_op (long_op)
  );

  smsu_ctrl #(.MW(MW)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .match    (match),
    .long_op  (long_op),
    .in_mask  (in_mask),
    .rpt_nz   (|rpt_cnt),
    .fire     (fire),
    .set_mask (set_mask),
    .done     (done),
    .rpt_clr  (rpt_clr)
  );

  smsu_flags #(.BW(BW)) u_lo (
    .clk      (clk),
    .rst      (rst),
    .we       (fire),
    .set_bits (set_mask[BW-1:0]),
    .q        (st_lo)
  );

  smsu_flags #(.BW(BW)) u_hi (
    .clk      (clk),
    .rst      (rst),
    .we       (fire),
    .set_bits (set_mask[MW-1:BW]),
    .q        (st_hi)
  );

  // R6
  both_words_same_edge_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(fire)));
endmodule

// File: tb/sim_stat_mask_set.sv
module sim_stat_mask_set;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_word = '0;
  logic [15:0] rpt_cnt = '0;
  logic        rpt_clr;
  logic [3:0]  st_lo, st_hi;
  logic        done;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [7:0] exp_f;

  always #5 clk = ~clk;

  stat_mask_set u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .rpt_cnt(rpt_cnt), .rpt_clr(rpt_clr),
    .st_lo(st_lo), .st_hi(st_hi), .done(done)
  );

  task automatic chk(input logic ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, expv, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    exp_f = '0;
    chk({st_hi, st_lo} == 8'h00, "R11 flags", {st_hi, st_lo}, 0);
    chk(!done && !rpt_clr, "R11 done/rpt_clr", {done, rpt_clr}, 0);
    chk(in_ready, "R11 ready", in_ready, 1);
  endtask

  task automatic exec(input logic [15:0] w, input logic [15:0] r);
    logic       hit, lng;
    logic [7:0] nf;
    hit = (w[15:8] == 8'h3B);
    lng = hit && (w[4] || w[5]);
    nf  = hit ? (exp_f | w[7:0]) : exp_f;
    @(negedge clk);
    chk(in_ready, "R7 ready idle", in_ready, 1);
    in_valid = 1'b1; in_word = w; rpt_cnt = r;
    @(negedge clk);
    in_valid = 1'b0;
    chk(rpt_clr == (hit && r != 0), "R9 rpt_clr", rpt_clr, hit && r != 0);
    if (!lng) begin
      chk(done == hit, hit ? "R5 done" : "R1 done", done, hit);
      chk({st_hi, st_lo} == nf, hit ? (w[7:0] == 0 ? "R10 flags" : "R2/R3/R4 flags") : "R1 flags",
          {st_hi, st_lo}, nf);
      chk(in_ready, "R5 ready", in_ready, 1);
    end else begin
      chk(!done, "R6 early done", done, 0);
      chk({st_hi, st_lo} == exp_f, "R6 early flags", {st_hi, st_lo}, exp_f);
      chk(!in_ready, "R6 ready low", in_ready, 0);
      in_valid = 1'b1; in_word = 16'h3BFF; rpt_cnt = 16'h0005;
      @(negedge clk);
      in_valid = 1'b0;
      chk(done, "R6 done", done, 1);
      chk({st_hi, st_lo} == nf, "R6 flags", {st_hi, st_lo}, nf);
      chk(!rpt_clr, "R9 single clr", rpt_clr, 0);
    end
    @(negedge clk);
    chk(!done, "R8 single done", done, 0);
    chk({st_hi, st_lo} == nf, "R7 no intruder", {st_hi, st_lo}, nf);
    chk(!rpt_clr, "R9 clr pulse", rpt_clr, 0);
    exp_f = nf;
  endtask

  initial begin
    exp_f = '0;
    do_reset();
    for (int m = 0; m < 256; m++) begin
      logic [7:0] p;
      do_reset();
      p = 8'((m * 53 + 29) & 255);
      exec({8'h3B, p}, 16'h0000);
      exec({8'h3B, 8'(m)}, (m % 3 == 0) ? 16'h0000 : 16'(m));
      exec({8'h3B ^ (8'h01 << (m % 8)), 8'hFF}, 16'h0001);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule